// File: doc/BRIEF.md
# Dual-Clock One-Word Mailbox

The block carries a single data word from a writer running on clock B to a reader running on clock A. It is the one-way message slot beside the bulk storage of a bidirectional dual-port buffer: the writer drops a word in, an active-low "mail full" flag tells it the slot is taken, and the reader empties the slot by reading it. While the flag is low, the writer cannot place another word, so no message is ever lost by overwriting.

Each port has a direction select, where high means write and low means read, and a mailbox select. Both are sampled on that port's own rising clock edge. A write event in domain B and a read-clear event in domain A are each carried across as a toggle bit through a chain of synchronizer flops. The flag is therefore always a clean register decode in the writer's domain. The data register only changes while the slot is empty, so the reader can capture it directly once the synchronized toggle shows it is full.

The reset input is asynchronous and active low. Its release is synchronized separately into each clock domain.

Top module: `mbx_mailbox`

## Requirements
- R1: A clock-B rising edge with `b_dir_wr`=1, `b_mbx_sel`=1 and `mbx_full_n`=1 stores `b_wdata`. It drives `mbx_full_n` low right after that edge.
- R2: While `mbx_full_n` is low, write attempts on port B are ignored. The stored word stays the one that set the flag.
- R3: A clock-A rising edge with `a_dir_wr`=0 and `a_mbx_sel`=1 while a word is pending presents the stored word on `a_rdata` right after that edge. The word is consumed by that read.
- R4: After a consuming read, `mbx_full_n` returns high within SYNC_STAGES+1 clock-B rising edges (3 with default parameters).
- R5: A read while no word is pending leaves `a_rdata` at the last word read and leaves `mbx_full_n` high.
- R6: While `a_dir_wr`=1, `a_rdata` is driven to all zeros. When `a_dir_wr` returns to 0, the held word shows again.
- R7: Edges with the mailbox select low, or with the direction select set to the other operation, neither store nor consume a word.
- R8: Asserting `rst_n` low forces `mbx_full_n` high at once and discards any pending word. After reset, `a_rdata` reads zero.
- R9: A stored word can be consumed by a read on the third clock-A rising edge after the storing clock-B edge (SYNC_STAGES+1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | Reader clock |
| clk_b | input | 1 | Writer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_dir_wr | input | 1 | Port A direction: 1 write, 0 read |
| a_mbx_sel | input | 1 | Port A mailbox select |
| b_dir_wr | input | 1 | Port B direction: 1 write, 0 read |
| b_mbx_sel | input | 1 | Port B mailbox select |
| b_wdata | input | DATA_W | Word offered by the writer |
| a_rdata | output | DATA_W | Word presented to the reader |
| mbx_full_n | output | 1 | Low while a word is pending |

## Verification
The bench writes a second word while the slot is still full and expects the first word on read. A design that let the write through would return the second word. Reads with no pending word must return the previous word, so a design that consumed on an empty slot or cleared the data register is caught by the scoreboard. Reads are also issued as early as the synchronizer allows, which exposes a design whose synchronizer is too slow. The bench checks that the flag recovers within its bound, that a mid-flight reset drops the pending word, and that edges with a wrong select or direction move nothing.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
   localparam logic DIR_WRITE = 1'b1;
   localparam logic DIR_READ  = 1'b0;

   function automatic logic tog_differ(input logic a, input logic b);
      return a ^ b;
   endfunction
endpackage

// File: rtl/mbx_rst_sync.sv
module mbx_rst_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic arst_n,
   output logic rst_n_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("mbx_rst_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) chain_q <= '0;
      else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
   end

   assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/mbx_tog_sync.sv
module mbx_tog_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tog_i,
   output logic tog_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("mbx_tog_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] stage_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q <= '0;
      else        stage_q <= {stage_q[STAGES-2:0], tog_i};
   end

   assign tog_o = stage_q[STAGES-1];
endmodule

// File: rtl/mbx_wr_side.sv
module mbx_wr_side
   import mbx_pkg::*;
#(
   parameter int DATA_W = 36,
   parameter int STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dir_wr,
   input  logic              mbx_sel,
   input  logic [DATA_W-1:0] wdata,
   input  logic              ack_tog_i,
   output logic              wr_tog_o,
   output logic [DATA_W-1:0] data_o,
   output logic              full_n_o
);
   logic              wr_tog_q;
   logic              ack_s;
   logic [DATA_W-1:0] data_q;
   logic              wr_fire;

   mbx_tog_sync #(.STAGES(STAGES)) u_ack_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .tog_i (ack_tog_i),
      .tog_o (ack_s)
   );

   assign full_n_o = !tog_differ(wr_tog_q, ack_s);
   assign wr_fire  = (dir_wr == DIR_WRITE) && mbx_sel && full_n_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_tog_q <= 1'b0;
         data_q   <= '0;
      end else if (wr_fire) begin
         wr_tog_q <= ~wr_tog_q;
         data_q   <= wdata;
      end
   end

   assign wr_tog_o = wr_tog_q;
   assign data_o   = data_q;

   AST_FLAG_LOW_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_fire |=> !full_n_o); // R1
   AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !full_n_o |=> $stable(data_q)); // R2
endmodule

// File: rtl/mbx_rd_side.sv
module mbx_rd_side
   import mbx_pkg::*;
#(
   parameter int DATA_W        = 36,
   parameter int STAGES        = 2,
   parameter bit MUTE_ON_WRITE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dir_wr,
   input  logic              mbx_sel,
   input  logic [DATA_W-1:0] mbx_data,
   input  logic              wr_tog_i,
   output logic              rd_tog_o,
   output logic [DATA_W-1:0] rdata
);
   logic              wr_s;
   logic              rd_tog_q;
   logic              avail;
   logic              rd_fire;
   logic [DATA_W-1:0] hold_q;

   mbx_tog_sync #(.STAGES(STAGES)) u_wr_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .tog_i (wr_tog_i),
      .tog_o (wr_s)
   );

   assign avail   = tog_differ(wr_s, rd_tog_q);
   assign rd_fire = (dir_wr == DIR_READ) && mbx_sel && avail;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_tog_q <= 1'b0;
         hold_q   <= '0;
      end else if (rd_fire) begin
         rd_tog_q <= ~rd_tog_q;
         hold_q   <= mbx_data;
      end
   end

   assign rd_tog_o = rd_tog_q;

   if (MUTE_ON_WRITE) begin : g_mute
      assign rdata = (dir_wr == DIR_WRITE) ? '0 : hold_q;
   end else begin : g_pass
      assign rdata = hold_q;
   end

   AST_READ_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_fire |=> (hold_q == $past(mbx_data))); // R3
   AST_EMPTY_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !avail |=> $stable(hold_q)); // R5
endmodule

// File: rtl/mbx_mailbox.sv
module mbx_mailbox #(
   parameter int DATA_W        = 36,
   parameter int SYNC_STAGES   = 2,
   parameter int RST_STAGES    = 2,
   parameter bit MUTE_ON_WRITE = 1'b1
) (
   input  logic              clk_a,
   input  logic              clk_b,
   input  logic              rst_n,
   input  logic              a_dir_wr,
   input  logic              a_mbx_sel,
   input  logic              b_dir_wr,
   input  logic              b_mbx_sel,
   input  logic [DATA_W-1:0] b_wdata,
   output logic [DATA_W-1:0] a_rdata,
   output logic              mbx_full_n
);
   if (DATA_W < 1) begin : g_bad_width
      $error("mbx_mailbox: DATA_W must be at least 1");
   end

   logic              rst_a_n;
   logic              rst_b_n;
   logic              wr_tog;
   logic              rd_tog;
   logic [DATA_W-1:0] slot_data;

   mbx_rst_sync #(.STAGES(RST_STAGES)) u_rst_a (
      .clk (clk_a), .arst_n (rst_n), .rst_n_o (rst_a_n)
   );
   mbx_rst_sync #(.STAGES(RST_STAGES)) u_rst_b (
      .clk (clk_b), .arst_n (rst_n), .rst_n_o (rst_b_n)
   );

   mbx_wr_side #(.DATA_W(DATA_W), .STAGES(SYNC_STAGES)) u_wr (
      .clk       (clk_b),
      .rst_n     (rst_b_n),
      .dir_wr    (b_dir_wr),
      .mbx_sel   (b_mbx_sel),
      .wdata     (b_wdata),
      .ack_tog_i (rd_tog),
      .wr_tog_o  (wr_tog),
      .data_o    (slot_data),
      .full_n_o  (mbx_full_n)
   );

   mbx_rd_side #(.DATA_W(DATA_W), .STAGES(SYNC_STAGES),
                 .MUTE_ON_WRITE(MUTE_ON_WRITE)) u_rd (
      .clk      (clk_a),
      .rst_n    (rst_a_n),
      .dir_wr   (a_dir_wr),
      .mbx_sel  (a_mbx_sel),
      .mbx_data (slot_data),
      .wr_tog_i (wr_tog),
      .rd_tog_o (rd_tog),
      .rdata    (a_rdata)
   );
endmodule

// File: tb/mbx_mailbox_test.sv
`timescale 1ns/100ps
module mbx_mailbox_test;
   localparam int W = 36;

   logic         clk_a = 1'b0;
   logic         clk_b = 1'b0;
   logic         rst_n = 1'b0;
   logic         a_dir_wr = 1'b0, a_mbx_sel = 1'b0;
   logic         b_dir_wr = 1'b0, b_mbx_sel = 1'b0;
   logic [W-1:0] b_wdata = '0;
   logic [W-1:0] a_rdata;
   logic         mbx_full_n;

   int vectors = 0;
   int fails   = 0;
   bit done    = 0;

   logic [W-1:0] exp_q[$];
   logic [W-1:0] last_word = '0;
   string        rd_tag;
   event         rd_ev;

   always #2.5 clk_a = ~clk_a;
   always #3.6 clk_b = ~clk_b;

   mbx_mailbox uut (
      .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n),
      .a_dir_wr(a_dir_wr), .a_mbx_sel(a_mbx_sel),
      .b_dir_wr(b_dir_wr), .b_mbx_sel(b_mbx_sel),
      .b_wdata(b_wdata), .a_rdata(a_rdata), .mbx_full_n(mbx_full_n)
   );

   task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   // driver: a write that should be accepted pushes onto the scoreboard
   task automatic b_write(input logic [W-1:0] d, input bit accept, input logic dir);
      @(negedge clk_b);
      b_dir_wr = dir; b_mbx_sel = 1'b1; b_wdata = d;
      @(posedge clk_b); #1;
      if (accept) exp_q.push_back(d);
      @(negedge clk_b);
      b_dir_wr = 1'b0; b_mbx_sel = 1'b0; b_wdata = '0;
   endtask

   task automatic a_read(input string tag);
      @(negedge clk_a);
      a_dir_wr = 1'b0; a_mbx_sel = 1'b1;
      @(posedge clk_a);
      @(negedge clk_a);
      a_mbx_sel = 1'b0;
      rd_tag = tag;
      ->rd_ev;
      #0;
   endtask

   // monitor: compare each read result with the scoreboard head
   always @(rd_ev) begin
      if (exp_q.size() > 0) last_word = exp_q.pop_front();
      chk(rd_tag, a_rdata, last_word);
   end

   task automatic wait_a(input int n);
      for (int i = 0; i < n; i++) @(posedge clk_a);
   endtask
   task automatic wait_b(input int n);
      for (int i = 0; i < n; i++) @(posedge clk_b);
   endtask

   initial begin
      #500000;
      if (!done) begin
         vectors++; fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      wait_b(6);
      rst_n = 1'b1;
      wait_b(6);
      #1;
      chk("R8 flag after reset", W'(mbx_full_n), W'(1));
      chk("R8 data after reset", a_rdata, '0);

      a_read("R5 empty read after reset");
      chk("R5 flag stays high", W'(mbx_full_n), W'(1));

      b_write(36'h1_2345_6789, 1'b1, 1'b1);
      chk("R1 flag low after write", W'(mbx_full_n), W'(0));
      b_write(36'hF_EDCB_A987, 1'b0, 1'b1);
      chk("R2 flag still low", W'(mbx_full_n), W'(0));
      b_write(36'h0_0BAD_0BAD, 1'b0, 1'b0);
      chk("R7 read-direction write ignored", W'(mbx_full_n), W'(0));

      wait_a(8);
      @(negedge clk_a); a_dir_wr = 1'b0; a_mbx_sel = 1'b0;
      @(posedge clk_a); @(negedge clk_a);
      chk("R7 unselected read keeps data", a_rdata, '0);
      wait_b(6); #1;
      chk("R7 unselected read keeps flag", W'(mbx_full_n), W'(0));

      a_read("R3 R2 first word read, blocked write dropped");
      wait_b(3); #1;
      chk("R4 flag released", W'(mbx_full_n), W'(1));

      a_read("R5 empty read holds word");
      wait_b(2); #1;
      chk("R5 flag unchanged", W'(mbx_full_n), W'(1));

      @(negedge clk_a); a_dir_wr = 1'b1; #1;
      chk("R6 muted while write selected", a_rdata, '0);
      @(negedge clk_a); a_dir_wr = 1'b0; #1;
      chk("R6 held word returns", a_rdata, last_word);

      for (int i = 0; i < 6; i++) begin
         logic [W-1:0] pat;
         case (i)
            0: pat = '1;
            1: pat = 36'hA_AAAA_AAAA;
            2: pat = 36'h5_5555_5555;
            3: pat = W'(1) << 35;
            4: pat = W'(1);
            default: pat = 36'h9_0F0F_1234;
         endcase
         b_write(pat, 1'b1, 1'b1);
         chk("R1 flag low in burst", W'(mbx_full_n), W'(0));
         if (i % 2 == 0) begin
            wait_a(2);
            a_read("R9 earliest read");
         end else begin
            wait_a(7);
            a_read("R3 burst read");
         end
         wait_b(3); #1;
         chk("R4 flag released in burst", W'(mbx_full_n), W'(1));
      end

      b_write(36'h7_7777_7777, 1'b1, 1'b1);
      @(negedge clk_b);
      rst_n = 1'b0; #1;
      chk("R8 reset raises flag at once", W'(mbx_full_n), W'(1));
      exp_q.delete();
      last_word = '0;
      wait_b(4);
      rst_n = 1'b1;
      wait_b(6); #1;
      chk("R8 data cleared by reset", a_rdata, '0);
      a_read("R8 pending word discarded");
      chk("R8 flag high after reset", W'(mbx_full_n), W'(1));

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule